// File: doc/BRIEF.md
# Vectored Interrupt Branch Injector

This block sits between 32 level-sensitive interrupt sources and a CPU that has only two interrupt entry modes: fast and normal. Each source has an enable bit and a mode bit. A global enable gates every request. The block raises the fast or normal request line to the CPU. When the CPU then fetches an instruction from that mode's fixed hardware vector, the block replaces the memory word with a branch instruction. The branch lands directly on the entry address of the winning source, so no software dispatch is needed.

Entry addresses are hardwired as `0x80 + 4*index`. Source 26 is the shared slot for external lines 4 to 7, and its entry is `0xE8`. The normal vector is fetched from `0x18` and the fast vector from `0x1C`. The branch word is `0xEA000000` OR'd with a 24-bit word offset of `(target - fetch_address - 8) >> 2`.

Fetches travel as a valid/ready stream: a request on `f_*` and a response on `r_*`, one cycle later. A fetch is accepted when `f_valid` and `f_ready` are both high. The rule is `f_ready = !r_valid || r_ready`, so a stalled response blocks new fetches. While `r_valid` is high and `r_ready` is low, `r_data` and `r_valid` hold.

Top module: `vbi_top`

## Requirements
- R1: After reset, `fast_req`, `norm_req` and `r_valid` are low, `f_ready` is high, and all enable, mode and global-enable bits are 0.
- R2: A source contributes to a request only while its pending input and its enable bit are both 1.
- R3: Mode bit 1 routes a source to `fast_req`; mode bit 0 routes it to `norm_req`.
- R4: `norm_req` is low whenever `fast_req` is high.
- R5: An instruction fetch (`f_instr`=1) of `0x18` while `norm_req` is high returns `0xEA000000 | (0x18 + i)`. An instruction fetch of `0x1C` while `fast_req` is high returns `0xEA000000 | (0x17 + i)`. In both cases i is the selected source index.
- R6: Among enabled pending sources of one mode, the lowest index is selected.
- R7: Any other accepted fetch returns `f_mem` unchanged. This covers data fetches (`f_instr`=0), other addresses, and a vector address whose mode request is low.
- R8: The selected index is latched when the fetch is accepted. A later change of pending inputs does not alter the response.
- R9: An accepted fetch yields `r_valid` on the next cycle, and `f_ready = !r_valid || r_ready`. While `r_valid` is high and `r_ready` is low, `r_data` stays stable.
- R10: With the global enable at 0, both request lines stay low and vector fetches pass memory data through.
- R11: Source 26 (shared external 4 to 7) branches to `0xE8`: word `0xEA000032` from the normal vector.
- R12: Configuration writes use `cfg_we` with `cfg_sel`: 0 writes the enable bits, 1 writes the mode bits, and 2 writes the global enable from `cfg_wdata[0]`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| src_pend | input | 32 | Level pending inputs, bit i is source i |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | 2 | Register select: 0 enable, 1 mode, 2 global |
| cfg_wdata | input | 32 | Configuration write data |
| fast_req | output | 1 | Fast-mode interrupt request to CPU |
| norm_req | output | 1 | Normal-mode interrupt request to CPU |
| f_valid | input | 1 | Fetch request valid |
| f_ready | output | 1 | Fetch request accepted when high with `f_valid` |
| f_addr | input | 32 | Fetch byte address |
| f_instr | input | 1 | 1 for instruction fetch, 0 for data access |
| f_mem | input | 32 | Memory word for the fetch address |
| r_valid | output | 1 | Response valid |
| r_ready | input | 1 | Response consumer ready |
| r_data | output | 32 | Memory word or synthesised branch |

## Verification
The bench walks every source index through both vectors. It uses pending patterns with all higher indices also set, so a priority encoder that favoured the top index, or a target off by one slot, would return a wrong branch offset. Pass-through cases cover:
- a data read of a vector address;
- a fetch of the fast vector with only a normal request pending;
- a normal-vector fetch that the fast request overrides.

A design that intercepted on address alone would return a branch instead of the memory word in these cases. A stalled response is held while a lower-index source appears, which exposes a design that re-reads the live index instead of the latched one or that drops data under back-pressure.

// File: rtl/vbi_pkg.sv
package vbi_pkg;

  typedef enum logic [1:0] {
    CFG_ENABLE = 2'd0,
    CFG_MODE   = 2'd1,
    CFG_GLOBAL = 2'd2
  } cfg_sel_e;

  typedef enum logic [1:0] {
    RSP_PASS = 2'd0,
    RSP_FAST = 2'd1,
    RSP_NORM = 2'd2
  } rsp_kind_e;

  localparam logic [7:0] BRANCH_OPC = 8'hEA;

  // Branch word: opcode byte then signed word offset (target - pc - 8) / 4
  function automatic logic [31:0] make_branch(input logic [31:0] target,
                                              input logic [31:0] pc);
    logic signed [31:0] diff;
    logic signed [31:0] words;
    diff  = signed'(target - pc - 32'd8);
    words = diff >>> 2;
    return {BRANCH_OPC, words[23:0]};
  endfunction

endpackage

// File: rtl/vbi_cfg_regs.sv
module vbi_cfg_regs
  import vbi_pkg::*;
#(
  parameter int unsigned NSRC = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            cfg_we,
  input  logic [1:0]      cfg_sel,
  input  logic [NSRC-1:0] cfg_wdata,
  output logic [NSRC-1:0] en_q,
  output logic [NSRC-1:0] mode_q,
  output logic            glb_q
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q   <= '0;
      mode_q <= '0;
      glb_q  <= 1'b0;
    end else if (cfg_we) begin
      unique case (cfg_sel)
        CFG_ENABLE: en_q   <= cfg_wdata;
        CFG_MODE:   mode_q <= cfg_wdata;
        CFG_GLOBAL: glb_q  <= cfg_wdata[0];
        default: ;
      endcase
    end
  end

endmodule

// File: rtl/vbi_lowest_first.sv
module vbi_lowest_first #(
  parameter int unsigned W  = 32,
  localparam int unsigned IW = $clog2(W)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [W-1:0]  vec,
  output logic          found,
  output logic [IW-1:0] idx
);

  always_comb begin
    found = 1'b0;
    idx   = '0;
    for (int i = W - 1; i >= 0; i--) begin
      if (vec[i]) begin
        found = 1'b1;
        idx   = IW'(i);
      end
    end
  end

  AST_PICK_IS_SET: assert property (@(posedge clk) disable iff (!rst_n)
    found |-> vec[idx]);  // R6
  AST_NONE_BELOW: assert property (@(posedge clk) disable iff (!rst_n)
    found |-> ((vec & ~({W{1'b1}} << idx)) == '0));  // R6

endmodule

// File: rtl/vbi_fetch_sub.sv
module vbi_fetch_sub
  import vbi_pkg::*;
#(
  parameter int unsigned  NSRC     = 32,
  parameter int unsigned  AW       = 32,
  parameter logic [31:0]  VEC_NORM = 32'h18,
  parameter logic [31:0]  VEC_FAST = 32'h1C,
  parameter logic [31:0]  TGT_BASE = 32'h80,
  localparam int unsigned IW       = $clog2(NSRC)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          f_valid,
  output logic          f_ready,
  input  logic [AW-1:0] f_addr,
  input  logic          f_instr,
  input  logic [31:0]   f_mem,
  output logic          r_valid,
  input  logic          r_ready,
  output logic [31:0]   r_data,
  input  logic          fast_req,
  input  logic          norm_req,
  input  logic [IW-1:0] fast_idx,
  input  logic [IW-1:0] norm_idx
);

  logic          accept, hit_fast, hit_norm;
  rsp_kind_e     kind_q;
  logic [IW-1:0] fast_idx_q, norm_idx_q;
  logic [31:0]   mem_q;
  logic          rv_q;

  assign f_ready  = !rv_q || r_ready;
  assign accept   = f_valid && f_ready;
  assign hit_fast = f_instr && (f_addr == AW'(VEC_FAST)) && fast_req;
  assign hit_norm = f_instr && (f_addr == AW'(VEC_NORM)) && norm_req;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rv_q       <= 1'b0;
      kind_q     <= RSP_PASS;
      fast_idx_q <= '0;
      norm_idx_q <= '0;
      mem_q      <= '0;
    end else if (accept) begin
      rv_q  <= 1'b1;
      mem_q <= f_mem;
      if (hit_fast) begin
        kind_q     <= RSP_FAST;
        fast_idx_q <= fast_idx;
      end else if (hit_norm) begin
        kind_q     <= RSP_NORM;
        norm_idx_q <= norm_idx;
      end else begin
        kind_q <= RSP_PASS;
      end
    end else if (r_ready) begin
      rv_q <= 1'b0;
    end
  end

  always_comb begin
    unique case (kind_q)
      RSP_FAST: r_data = make_branch(TGT_BASE + {{(32-IW-2){1'b0}}, fast_idx_q, 2'b00}, VEC_FAST);
      RSP_NORM: r_data = make_branch(TGT_BASE + {{(32-IW-2){1'b0}}, norm_idx_q, 2'b00}, VEC_NORM);
      default:  r_data = mem_q;
    endcase
  end

  assign r_valid = rv_q;

  AST_ACCEPT_RESP: assert property (@(posedge clk) disable iff (!rst_n)
    (f_valid && f_ready) |=> r_valid);  // R9
  AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (r_valid && !r_ready) |=> (r_valid && $stable(r_data)));  // R9
  AST_DATA_FETCH_PASS: assert property (@(posedge clk) disable iff (!rst_n)
    (f_valid && f_ready && !f_instr) |=> (r_data == $past(f_mem)));  // R7

endmodule

// File: rtl/vbi_top.sv
module vbi_top
  import vbi_pkg::*;
#(
  parameter int unsigned  NSRC     = 32,
  parameter int unsigned  AW       = 32,
  parameter logic [31:0]  VEC_NORM = 32'h18,
  parameter logic [31:0]  VEC_FAST = 32'h1C,
  parameter logic [31:0]  TGT_BASE = 32'h80,
  localparam int unsigned IW       = $clog2(NSRC)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NSRC-1:0] src_pend,
  input  logic            cfg_we,
  input  logic [1:0]      cfg_sel,
  input  logic [NSRC-1:0] cfg_wdata,
  output logic            fast_req,
  output logic            norm_req,
  input  logic            f_valid,
  output logic            f_ready,
  input  logic [AW-1:0]   f_addr,
  input  logic            f_instr,
  input  logic [31:0]     f_mem,
  output logic            r_valid,
  input  logic            r_ready,
  output logic [31:0]     r_data
);

  logic [NSRC-1:0] en_q, mode_q;
  logic            glb_q;
  logic [NSRC-1:0] live;
  logic [NSRC-1:0] by_mode [2];
  logic            any    [2];
  logic [IW-1:0]   pick   [2];

  vbi_cfg_regs #(.NSRC(NSRC)) u_cfg (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
    .cfg_wdata(cfg_wdata), .en_q(en_q), .mode_q(mode_q), .glb_q(glb_q)
  );

  assign live = src_pend & en_q & {NSRC{glb_q}};

  // index 0: normal mode, index 1: fast mode
  for (genvar m = 0; m < 2; m++) begin : g_mode
    assign by_mode[m] = (m == 1) ? (live & mode_q) : (live & ~mode_q);
    vbi_lowest_first #(.W(NSRC)) u_pick (
      .clk(clk), .rst_n(rst_n), .vec(by_mode[m]),
      .found(any[m]), .idx(pick[m])
    );
  end

  assign fast_req = any[1];
  assign norm_req = any[0] && !any[1];

  vbi_fetch_sub #(
    .NSRC(NSRC), .AW(AW), .VEC_NORM(VEC_NORM), .VEC_FAST(VEC_FAST),
    .TGT_BASE(TGT_BASE)
  ) u_fetch (
    .clk(clk), .rst_n(rst_n),
    .f_valid(f_valid), .f_ready(f_ready), .f_addr(f_addr),
    .f_instr(f_instr), .f_mem(f_mem),
    .r_valid(r_valid), .r_ready(r_ready), .r_data(r_data),
    .fast_req(fast_req), .norm_req(norm_req),
    .fast_idx(pick[1]), .norm_idx(pick[0])
  );

  AST_REQ_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(fast_req && norm_req));  // R4
  AST_MASKED_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !glb_q |-> (!fast_req && !norm_req));  // R10
  AST_NO_REQ_UNPENDING: assert property (@(posedge clk) disable iff (!rst_n)
    ((src_pend & en_q) == '0) |-> (!fast_req && !norm_req));  // R2

endmodule

// File: tb/vbi_top_test.sv
module vbi_top_test;

  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] src_pend = '0;
  logic        cfg_we = 1'b0;
  logic [1:0]  cfg_sel = '0;
  logic [31:0] cfg_wdata = '0;
  logic        fast_req, norm_req;
  logic        f_valid = 1'b0;
  logic        f_ready;
  logic [31:0] f_addr = '0;
  logic        f_instr = 1'b0;
  logic [31:0] f_mem = '0;
  logic        r_valid;
  logic        r_ready = 1'b1;
  logic [31:0] r_data;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  vbi_top uut (
    .clk(clk), .rst_n(rst_n), .src_pend(src_pend),
    .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata),
    .fast_req(fast_req), .norm_req(norm_req),
    .f_valid(f_valid), .f_ready(f_ready), .f_addr(f_addr),
    .f_instr(f_instr), .f_mem(f_mem),
    .r_valid(r_valid), .r_ready(r_ready), .r_data(r_data)
  );

  typedef struct packed {
    logic [31:0] en;
    logic [31:0] mode;
    logic [31:0] pend;
    logic [31:0] addr;
    logic        instr;
    logic [31:0] mem;
    logic        xfast;
    logic        xnorm;
    logic [31:0] xdata;
  } row_t;

  localparam int NROWS = 8;
  localparam row_t TBL [NROWS] = '{
    '{32'hFFFF_FFFF, 32'h0, 32'h0000_0008, 32'h18, 1'b0, 32'hA5A5_0001, 1'b0, 1'b1, 32'hA5A5_0001},
    '{32'hFFFF_FFFF, 32'h0, 32'h0000_0008, 32'h20, 1'b1, 32'hA5A5_0002, 1'b0, 1'b1, 32'hA5A5_0002},
    '{32'hFFFF_FFFF, 32'h0, 32'h0000_0008, 32'h1C, 1'b1, 32'hA5A5_0003, 1'b0, 1'b1, 32'hA5A5_0003},
    '{32'hFFFF_FFFF, 32'h20, 32'h0000_0024, 32'h18, 1'b1, 32'hA5A5_0004, 1'b1, 1'b0, 32'hA5A5_0004},
    '{32'hFFFF_FFFF, 32'h20, 32'h0000_0024, 32'h1C, 1'b1, 32'hA5A5_0005, 1'b1, 1'b0, 32'hEA00_001C},
    '{32'hFFFF_FDFF, 32'h0, 32'h0000_0200, 32'h18, 1'b1, 32'hA5A5_0006, 1'b0, 1'b0, 32'hA5A5_0006},
    '{32'hFFFF_FFFF, 32'h0, 32'h0400_0000, 32'h18, 1'b1, 32'hA5A5_0007, 1'b0, 1'b1, 32'hEA00_0032},
    '{32'hFFFF_FFFF, 32'h2, 32'h0000_0003, 32'h1C, 1'b1, 32'hA5A5_0008, 1'b1, 1'b0, 32'hEA00_0018}
  };

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=0x%08h expected=0x%08h", tag, act, exp);
    end
  endtask

  task automatic cfg_write(input logic [1:0] sel, input logic [31:0] data);
    @(negedge clk);
    cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = data;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  // Drive one accepted fetch; return response sampled just after the capturing edge
  task automatic do_fetch(input logic [31:0] addr, input logic instr,
                          input logic [31:0] mem, output logic [31:0] data);
    @(negedge clk);
    f_valid = 1'b1; f_addr = addr; f_instr = instr; f_mem = mem; r_ready = 1'b1;
    @(posedge clk);
    #1;
    f_valid = 1'b0;
    data = r_data;
    checks++;
    if (r_valid !== 1'b1) begin
      errors++;
      $display("FAIL R9 r_valid after accept actual=%0b expected=1", r_valid);
    end
  endtask

  function automatic logic [31:0] exp_branch(input int idx, input logic [31:0] pc);
    logic [31:0] off;
    off = (32'h80 + 32'(idx) * 4 - pc - 32'd8) >> 2;
    return 32'hEA00_0000 | {8'h0, off[23:0]};
  endfunction

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin : main
    logic [31:0] d;
    repeat (3) @(posedge clk);
    #1;
    // R1 reset state
    check("R1 fast_req", {31'b0, fast_req}, 32'd0);
    check("R1 norm_req", {31'b0, norm_req}, 32'd0);
    check("R1 r_valid", {31'b0, r_valid}, 32'd0);
    check("R1 f_ready", {31'b0, f_ready}, 32'd1);
    @(negedge clk);
    rst_n = 1'b1;
    src_pend = 32'hFFFF_FFFF;
    #1;
    check("R1 no request with config cleared", {30'b0, fast_req, norm_req}, 32'd0);

    // R12 global enable write, R10 gating
    cfg_write(2'd0, 32'hFFFF_FFFF);
    #1;
    check("R10 global off keeps lines low", {30'b0, fast_req, norm_req}, 32'd0);
    do_fetch(32'h18, 1'b1, 32'h1357_9BDF, d);
    check("R10 vector fetch passes with global off", d, 32'h1357_9BDF);
    cfg_write(2'd2, 32'h1);
    #1;
    check("R12 global write enables normal line", {30'b0, fast_req, norm_req}, 32'd1);

    // table walk: R2 R3 R4 R5 R7 R11
    for (int r = 0; r < NROWS; r++) begin
      cfg_write(2'd0, TBL[r].en);
      cfg_write(2'd1, TBL[r].mode);
      src_pend = TBL[r].pend;
      #1;
      check($sformatf("R2/R3/R4 table row %0d request lines", r),
            {30'b0, fast_req, norm_req}, {30'b0, TBL[r].xfast, TBL[r].xnorm});
      do_fetch(TBL[r].addr, TBL[r].instr, TBL[r].mem, d);
      check($sformatf("R5/R7/R11 table row %0d data", r), d, TBL[r].xdata);
    end

    // every source through both vectors, with all higher indices pending (R5, R6)
    cfg_write(2'd0, 32'hFFFF_FFFF);
    cfg_write(2'd1, 32'h0);
    for (int i = 0; i < 32; i++) begin
      src_pend = 32'hFFFF_FFFF << i;
      do_fetch(32'h18, 1'b1, 32'hDEAD_0000, d);
      check($sformatf("R5 R6 normal source %0d", i), d, exp_branch(i, 32'h18));
    end
    cfg_write(2'd1, 32'hFFFF_FFFF);
    for (int i = 0; i < 32; i++) begin
      src_pend = 32'hFFFF_FFFF << i;
      do_fetch(32'h1C, 1'b1, 32'hBEEF_0000, d);
      check($sformatf("R5 R6 fast source %0d", i), d, exp_branch(i, 32'h1C));
    end

    // R8 latch and R9 back-pressure
    cfg_write(2'd1, 32'h0);
    src_pend = 32'h0000_0010;
    @(negedge clk);
    f_valid = 1'b1; f_addr = 32'h18; f_instr = 1'b1; f_mem = 32'h0; r_ready = 1'b0;
    @(posedge clk);
    #1;
    f_valid = 1'b0;
    src_pend = 32'h0000_0011;
    check("R9 f_ready low while stalled", {31'b0, f_ready}, 32'd0);
    @(posedge clk);
    #1;
    check("R9 r_valid held", {31'b0, r_valid}, 32'd1);
    check("R8 latched index survives new lower source", r_data, exp_branch(4, 32'h18));
    @(negedge clk);
    r_ready = 1'b1;
    @(posedge clk);
    #1;
    check("R9 r_valid drops after consume", {31'b0, r_valid}, 32'd0);
    check("R9 f_ready high when idle", {31'b0, f_ready}, 32'd1);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule